// File: doc/BRIEF.md
# Wake-on-LAN Power Management Controller

This block manages a receiver's low-power mode. Software picks one or more wake sources and then sets a power-down flag. The flag is accepted only while the receiver is enabled, so incoming frames are still examined while the block is powered down. Three detectors inspect every frame, one byte per clock:

- a magic-packet search,
- a destination-address match against the station address,
- a fixed-offset pattern compare.

When a frame ends with a good CRC while the block is powered down, and an enabled detector reports a hit, the block does four things. It records which sources fired, sets a pending power-management interrupt, leaves power-down on its own, and drives the interrupt output unless the mask bit suppresses it.

Software talks to the block through a small register port. Address 0 holds the control/status word, and reading it clears the pending interrupt and the source flags. Address 1 holds the interrupt mask. Read data comes back one clock after the read strobe, marked by a valid flag. The raw pending state is brought out on its own pin, which lets a system-level interrupt controller see which submodule raised the event.

Top module: `wol_pm_ctrl`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x00. Its bits are:
  - bit 0: power-down
  - bit 1: magic-packet enable
  - bit 2: unicast enable
  - bit 3: pattern enable
  - bit 4: always 0
  - bit 5: magic seen
  - bit 6: unicast seen
  - bit 7: pattern seen
  
  A write to address 0 sets bits 3..1 from the written data.
- R2: Writing 1 to bit 0 at address 0 enters power-down only if `rx_en` is high in that cycle; otherwise bit 0 stays 0. Writing 0 to bit 0 leaves power-down.
- R3: A magic packet is detected when the frame carries at least six consecutive 0xFF bytes followed by sixteen back-to-back copies of the station address, each copy sent most significant byte first (`station_addr[47:40]` first). Any mismatch restarts the search.
- R4: A unicast hit occurs when the first six bytes of the frame equal the station address, most significant byte first.
- R5: A pattern hit occurs when frame bytes 14, 15, 16 and 17 (counting from 0 at the start-of-frame byte) are 0xC0, 0xFF, 0xEE and 0x01.
- R6: A frame causes a wake only if its last byte (`rx_eof`) arrives with `rx_crc_ok` high. A frame with a bad CRC never wakes the block.
- R7: A good frame that ends while powered down, and that hits at least one enabled source, does three things on the clock edge that takes its last byte: it clears power-down, sets `irq_raw`, and sets the seen bit of every enabled source that hit.
- R8: A read of address 0 returns the word as it was before the read, one cycle later with `reg_rvalid` high. It also clears the seen bits and `irq_raw`, unless a wake occurs in the same cycle.
- R9: The mask is bit 0 at address 1 and reads back there. `irq` equals `irq_raw` while the mask is 0 and stays low while the mask is 1.
- R10: Frames that end while not powered down never set the seen bits or `irq_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_crc_ok | input | 1 | CRC good, sampled with last byte |
| rx_en | input | 1 | Receiver enabled |
| station_addr | input | 48 | Station MAC address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0: control/status, 1: mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| pd_active | output | 1 | Power-down state |
| irq_raw | output | 1 | Pending power-management event |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check four rules on every cycle:
- `irq_raw` only rises after a good-CRC frame end that was seen while powered down.
- A rise of `irq_raw` always comes with power-down cleared.
- Power-down is only entered through a write made while the receiver was enabled.
- A status read with no frame end in the same cycle leaves nothing pending.

Only the bench scenarios can show that each detector recognises its own frame shape and rejects near misses, such as a corrupted address copy or a wrong pattern byte. The same holds for these checks:
- the seen bits report exactly the enabled sources that hit,
- masking hides the interrupt pin but not the raw flag,
- read data carries the pre-clear word.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int PM_W  = 8;
  localparam int B_PD  = 0;
  localparam int B_MEN = 1;
  localparam int B_UEN = 2;
  localparam int B_PEN = 3;
  localparam int B_MST = 5;
  localparam int B_UST = 6;
  localparam int B_PST = 7;

  typedef struct packed {
    logic magic;
    logic ucast;
    logic pattern;
  } wake_hits_t;
endpackage

// File: rtl/wol_magic_det.sv
module wol_magic_det #(
  parameter int SYNC_LEN = 6,
  parameter int REPS     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  logic        sof,
  input  logic [7:0]  data,
  input  logic [47:0] station,
  output logic        hit
);
  localparam int ABYTES = 6;
  localparam int TOTAL  = ABYTES * REPS;
  localparam int SW     = $clog2(SYNC_LEN + 1);
  localparam int AW     = $clog2(TOTAL + 1);
  localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
  localparam logic [AW-1:0] AIDX_END  = AW'(TOTAL);

  logic [SW-1:0] sync_q, sync_c, sync_d;
  logic [AW-1:0] aidx_q, aidx_c, aidx_d;
  logic [2:0]    bidx_q, bidx_c, bidx_d;
  logic          found_q, found_c, found_d;
  logic [7:0]    exp_byte;

  always_comb begin
    exp_byte = 8'h00;
    for (int k = 0; k < ABYTES; k++) begin
      if (bidx_c == 3'(k)) exp_byte = station[47 - 8*k -: 8];
    end
  end

  always_comb begin
    sync_c  = sof ? '0 : sync_q;
    aidx_c  = sof ? '0 : aidx_q;
    bidx_c  = sof ? '0 : bidx_q;
    found_c = sof ? 1'b0 : found_q;
    sync_d  = sync_c;
    aidx_d  = aidx_c;
    bidx_d  = bidx_c;
    found_d = found_c;
    if (vld && !found_c) begin
      if (sync_c == SYNC_FULL) begin
        if (data == exp_byte) begin
          aidx_d = aidx_c + 1'b1;
          bidx_d = (bidx_c == 3'(ABYTES - 1)) ? 3'd0 : bidx_c + 3'd1;
          if (aidx_c + 1'b1 == AIDX_END) found_d = 1'b1;
        end else if (aidx_c == '0 && data == 8'hFF) begin
          sync_d = sync_c;
        end else begin
          aidx_d = '0;
          bidx_d = '0;
          sync_d = (data == 8'hFF) ? SW'(1) : '0;
        end
      end else begin
        sync_d = (data == 8'hFF) ? sync_c + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      aidx_q  <= '0;
      bidx_q  <= '0;
      found_q <= 1'b0;
    end else if (vld) begin
      sync_q  <= sync_d;
      aidx_q  <= aidx_d;
      bidx_q  <= bidx_d;
      found_q <= found_d;
    end
  end

  assign hit = found_d;
endmodule

// File: rtl/wol_ucast_det.sv
module wol_ucast_det (
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  logic        sof,
  input  logic [7:0]  data,
  input  logic [47:0] station,
  output logic        hit
);
  localparam int ABYTES = 6;

  logic [2:0] cnt_q, cnt_c, cnt_d;
  logic       match_q, match_c, match_d;
  logic [7:0] exp_byte;

  always_comb begin
    exp_byte = 8'h00;
    for (int k = 0; k < ABYTES; k++) begin
      if (cnt_c == 3'(k)) exp_byte = station[47 - 8*k -: 8];
    end
  end

  always_comb begin
    cnt_c   = sof ? 3'd0 : cnt_q;
    match_c = sof ? 1'b1 : match_q;
    cnt_d   = cnt_c;
    match_d = match_c;
    if (vld && cnt_c < 3'(ABYTES)) begin
      cnt_d = cnt_c + 3'd1;
      if (data != exp_byte) match_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= 3'd0;
      match_q <= 1'b0;
    end else if (vld) begin
      cnt_q   <= cnt_d;
      match_q <= match_d;
    end
  end

  assign hit = (cnt_d == 3'(ABYTES)) && match_d;
endmodule

// File: rtl/wol_pattern_det.sv
module wol_pattern_det #(
  parameter int              PAT_OFS   = 14,
  parameter int              PAT_LEN   = 4,
  parameter logic [8*PAT_LEN-1:0] PAT_BYTES = 32'hC0FF_EE01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld,
  input  logic       sof,
  input  logic [7:0] data,
  output logic       hit
);
  localparam int PEND = PAT_OFS + PAT_LEN;
  localparam int PW   = $clog2(PEND + 1);
  localparam logic [PW-1:0] OFS_V = PW'(PAT_OFS);
  localparam logic [PW-1:0] END_V = PW'(PEND);

  logic [PW-1:0] pos_q, pos_c, pos_d;
  logic          ok_q, ok_c, ok_d;
  logic [7:0]    exp_byte;

  always_comb begin
    exp_byte = 8'h00;
    for (int k = 0; k < PAT_LEN; k++) begin
      if (pos_c == PW'(PAT_OFS + k)) exp_byte = PAT_BYTES[8*(PAT_LEN-1-k) +: 8];
    end
  end

  always_comb begin
    pos_c = sof ? '0 : pos_q;
    ok_c  = sof ? 1'b1 : ok_q;
    pos_d = pos_c;
    ok_d  = ok_c;
    if (vld && pos_c < END_V) begin
      pos_d = pos_c + 1'b1;
      if (pos_c >= OFS_V && data != exp_byte) ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      ok_q  <= 1'b0;
    end else if (vld) begin
      pos_q <= pos_d;
      ok_q  <= ok_d;
    end
  end

  assign hit = (pos_d == END_V) && ok_d;
endmodule

// File: rtl/wol_pm_regs.sv
module wol_pm_regs
  import wol_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic            reg_addr,
  input  logic [PM_W-1:0] reg_wdata,
  input  logic            rx_en,
  input  logic            frame_good,
  input  wake_hits_t      hits,
  output logic [PM_W-1:0] reg_rdata,
  output logic            reg_rvalid,
  output logic            pd,
  output logic            pend,
  output logic            mask
);
  logic       en_m, en_u, en_p;
  logic       st_m, st_u, st_p;
  wake_hits_t fired;
  logic       wake;
  logic [PM_W-1:0] word;

  always_comb begin
    word        = '0;
    word[B_PD]  = pd;
    word[B_MEN] = en_m;
    word[B_UEN] = en_u;
    word[B_PEN] = en_p;
    word[B_MST] = st_m;
    word[B_UST] = st_u;
    word[B_PST] = st_p;
  end

  assign fired.magic   = en_m && hits.magic;
  assign fired.ucast   = en_u && hits.ucast;
  assign fired.pattern = en_p && hits.pattern;
  assign wake = pd && frame_good && (fired != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      pd   <= 1'b0;
      pend <= 1'b0;
      mask <= 1'b0;
      en_m <= 1'b0; en_u <= 1'b0; en_p <= 1'b0;
      st_m <= 1'b0; st_u <= 1'b0; st_p <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= reg_addr ? {{(PM_W-1){1'b0}}, mask} : word;
      if (reg_wr && !reg_addr) begin
        en_m <= reg_wdata[B_MEN];
        en_u <= reg_wdata[B_UEN];
        en_p <= reg_wdata[B_PEN];
        if (!reg_wdata[B_PD]) pd <= 1'b0;
        else if (rx_en)       pd <= 1'b1;
      end
      if (reg_wr && reg_addr) mask <= reg_wdata[0];
      if (reg_rd && !reg_addr) begin
        st_m <= 1'b0; st_u <= 1'b0; st_p <= 1'b0;
        pend <= 1'b0;
      end
      if (wake) begin
        pd   <= 1'b0;
        pend <= 1'b1;
        if (fired.magic)   st_m <= 1'b1;
        if (fired.ucast)   st_u <= 1'b1;
        if (fired.pattern) st_p <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wol_pm_ctrl.sv
module wol_pm_ctrl
  import wol_pkg::*;
#(
  parameter int SYNC_LEN = 6,
  parameter int REPS     = 16,
  parameter int PAT_OFS  = 14,
  parameter int PAT_LEN  = 4,
  parameter logic [8*PAT_LEN-1:0] PAT_BYTES = 32'hC0FF_EE01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_crc_ok,
  input  logic        rx_en,
  input  logic [47:0] station_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        reg_rvalid,
  output logic        pd_active,
  output logic        irq_raw,
  output logic        irq
);
  wake_hits_t hits;
  logic       frame_good;
  logic       mask;
  logic       sof_v;

  assign sof_v      = rx_valid && rx_sof;
  assign frame_good = rx_valid && rx_eof && rx_crc_ok;

  wol_magic_det #(.SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_magic (
    .clk(clk), .rst(rst), .vld(rx_valid), .sof(sof_v), .data(rx_data),
    .station(station_addr), .hit(hits.magic));

  wol_ucast_det u_ucast (
    .clk(clk), .rst(rst), .vld(rx_valid), .sof(sof_v), .data(rx_data),
    .station(station_addr), .hit(hits.ucast));

  wol_pattern_det #(.PAT_OFS(PAT_OFS), .PAT_LEN(PAT_LEN), .PAT_BYTES(PAT_BYTES)) u_pat (
    .clk(clk), .rst(rst), .vld(rx_valid), .sof(sof_v), .data(rx_data),
    .hit(hits.pattern));

  wol_pm_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_en(rx_en), .frame_good(frame_good), .hits(hits),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .pd(pd_active),
    .pend(irq_raw), .mask(mask));

  assign irq = irq_raw && !mask;
endmodule

// File: rtl/wol_pm_ctrl_chk.sv
module wol_pm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_crc_ok,
  input logic rx_en,
  input logic reg_wr,
  input logic reg_rd,
  input logic reg_addr,
  input logic reg_rvalid,
  input logic pd_active,
  input logic irq_raw
);
  // R6
  good_eof_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_raw) |-> $past(rx_valid && rx_eof && rx_crc_ok));

  // R7
  wake_exits_pd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_raw) |-> !pd_active);

  // R10
  wake_needs_pd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_raw) |-> $past(pd_active));

  // R2
  pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> $past(reg_wr && !reg_addr && rx_en));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_addr && !(rx_valid && rx_eof)) |=> !irq_raw);

  // R8
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid |-> $past(reg_rd));
endmodule

bind wol_pm_ctrl wol_pm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .rx_crc_ok(rx_crc_ok), .rx_en(rx_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .pd_active(pd_active),
  .irq_raw(irq_raw));

// File: tb/wol_pm_ctrl_tb.sv
`timescale 1ns/1ps
module wol_pm_ctrl_tb;
  localparam logic [47:0] STA   = 48'h0211_2233_4455;
  localparam logic [47:0] OTHER = 48'h0A0B_0C0D_0E0F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0, rx_en = 0;
  logic [7:0] rx_data = 0;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic reg_rvalid, pd_active, irq_raw, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] frm[$];

  always #2 clk = ~clk;

  wol_pm_ctrl u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_en(rx_en),
    .station_addr(STA), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .pd_active(pd_active), .irq_raw(irq_raw), .irq(irq));

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (reg_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data: actual %02h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read actual %02h expected %02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    @(negedge clk);
  endtask

  task automatic add_addr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) frm.push_back(a[47 - 8*k -: 8]);
  endtask

  task automatic pad_to(input int n);
    while (frm.size() < n) frm.push_back(8'h5A);
  endtask

  task automatic send(input logic crc);
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = frm[i];
      rx_sof = (i == 0);
      rx_eof = (i == frm.size() - 1);
      rx_crc_ok = (i == frm.size() - 1) ? crc : 1'b0;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0;
    frm.delete();
  endtask

  task automatic build_magic(input logic [47:0] dst, input int bad_copy);
    frm.delete();
    add_addr(dst);
    add_addr(OTHER);
    frm.push_back(8'h08); frm.push_back(8'h42);
    for (int k = 0; k < 6; k++) frm.push_back(8'hFF);
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 6; k++) begin
        if (c == bad_copy && k == 3) frm.push_back(8'h99);
        else frm.push_back(STA[47 - 8*k -: 8]);
      end
    end
    frm.push_back(8'h00); frm.push_back(8'h11);
  endtask

  task automatic build_ucast(input logic [47:0] dst);
    frm.delete();
    add_addr(dst);
    add_addr(OTHER);
    pad_to(64);
  endtask

  task automatic build_pattern(input logic [7:0] b3);
    frm.delete();
    add_addr(OTHER);
    add_addr(OTHER);
    frm.push_back(8'h08); frm.push_back(8'h00);
    frm.push_back(8'hC0); frm.push_back(8'hFF); frm.push_back(8'hEE); frm.push_back(b3);
    pad_to(64);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pd reset", pd_active, 1'b0);
    chk("R1 irq_raw reset", irq_raw, 1'b0);
    rd(1'b0, 8'h00, "R1 reset word");
    // R2 power-down refused with receiver off
    wr(1'b0, 8'h01);
    rd(1'b0, 8'h00, "R2 pd needs rx_en");
    rx_en = 1;
    wr(1'b0, 8'h03);
    rd(1'b0, 8'h03, "R2 pd entered magic enabled");
    // R4/R7 unicast hit but source not enabled
    build_ucast(STA); send(1'b1);
    chk("R7 disabled source no wake", irq_raw, 1'b0);
    rd(1'b0, 8'h03, "R7 disabled source word");
    // R6 bad CRC magic
    build_magic(OTHER, -1); send(1'b0);
    chk("R6 bad crc no wake", irq_raw, 1'b0);
    rd(1'b0, 8'h03, "R6 bad crc word");
    // R3 broken copy
    build_magic(OTHER, 5); send(1'b1);
    chk("R3 broken copy no wake", irq_raw, 1'b0);
    rd(1'b0, 8'h03, "R3 broken copy word");
    // R3/R7 valid magic
    build_magic(OTHER, -1); send(1'b1);
    chk("R7 irq_raw set", irq_raw, 1'b1);
    chk("R9 irq unmasked", irq, 1'b1);
    chk("R7 pd cleared", pd_active, 1'b0);
    rd(1'b0, 8'h22, "R3 magic word");
    chk("R8 irq_raw cleared", irq_raw, 1'b0);
    rd(1'b0, 8'h02, "R8 status cleared");
    // R9 mask
    wr(1'b1, 8'h01);
    rd(1'b1, 8'h01, "R9 mask readback");
    wr(1'b0, 8'h05);
    build_ucast(STA); send(1'b1);
    chk("R9 raw with mask", irq_raw, 1'b1);
    chk("R9 irq masked", irq, 1'b0);
    rd(1'b0, 8'h44, "R4 unicast word");
    wr(1'b1, 8'h00);
    // R10 not powered down
    wr(1'b0, 8'h04);
    build_ucast(STA); send(1'b1);
    chk("R10 no wake awake", irq_raw, 1'b0);
    rd(1'b0, 8'h04, "R10 word");
    // R5 pattern
    wr(1'b0, 8'h09);
    build_pattern(8'h02); send(1'b1);
    chk("R5 wrong pattern no wake", irq_raw, 1'b0);
    rd(1'b0, 8'h09, "R5 wrong pattern word");
    build_pattern(8'h01); send(1'b1);
    chk("R5 pattern wake", irq, 1'b1);
    rd(1'b0, 8'h88, "R5 pattern word");
    // R4 wrong destination, then combined hit
    wr(1'b0, 8'h07);
    build_ucast(OTHER); send(1'b1);
    chk("R4 other dest no wake", irq_raw, 1'b0);
    rd(1'b0, 8'h07, "R4 other dest word");
    build_magic(STA, -1); send(1'b1);
    chk("R7 combined wake", irq_raw, 1'b1);
    rd(1'b0, 8'h66, "R7 both sources word");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 reads missing: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule